// File: doc/BRIEF.md
# Three-Channel Tick Timer with Compare Interrupts

This block holds three free-running 63-bit tick counters: one for the processor, one for the system and one for the hypervisor. Each counter has its own compare register. Bit 63 of a compare register is an interrupt-disable flag, and bits 62:0 hold the compare value. When a counter first becomes equal to an enabled compare value, the block raises a one-cycle timer interrupt request. For the processor and system channels it also sets a sticky bit in a 17-bit soft-interrupt vector.

Software reaches the block through a small register port. A write selects a channel and either its counter or its compare register. A read returns, one clock later, the selected counter (zero-extended) or the full compare register. Soft-interrupt bits stay set until a write-one-to-clear strobe removes them. Interrupt priority and trap handling belong to the consumer of `softint` and `timer_irq`.

Top module: `tick_cmp_bank`

## Requirements
- R1: After a synchronous reset, `softint` is 0, `timer_irq` is 0, every compare register reads 0x8000_0000_0000_0000 (disabled, value 0), and every counter is already running from 0.
- R2: With `TICK_DIV` = 1, each counter advances by one every clock and wraps from 0x7FFF_FFFF_FFFF_FFFF to 0.
- R3: Writing a counter (`wr_field` = 0) loads `wr_data[62:0]`, and bit 63 is ignored. A read issued k clocks after the write edge returns the written value plus k-1.
- R4: Channel select is `wr_tmr`/`rd_tmr`: 0 = processor, 1 = system, 2 = hypervisor. `rd_field` = 1 returns the full 64-bit compare register, and `rd_field` = 0 returns the counter with bit 63 zero. Read data is registered.
- R5: While compare bit 63 is set, reaching the compare value produces no `timer_irq` and changes no `softint` bit.
- R6: A processor-channel match sets `softint[0]` and pulses `timer_irq` in the clock after the counter holds the compare value.
- R7: A system-channel match sets `softint[16]` and pulses `timer_irq`.
- R8: A hypervisor-channel match pulses `timer_irq` and leaves `softint` unchanged.
- R9: A match fires once per entry into equality, so `timer_irq` lasts one clock.
- R10: `softint` bits are sticky. A clock with `sint_clr` = 1 clears exactly the bits set in `sint_clr_mask`.
- R11: When a clear and a new match on the same bit fall in the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_tmr | input | 2 | Channel selected for the write |
| wr_field | input | 1 | 0 = counter, 1 = compare register |
| wr_data | input | 64 | Write data |
| rd_tmr | input | 2 | Channel selected for the read |
| rd_field | input | 1 | 0 = counter, 1 = compare register |
| rd_data | output | 64 | Registered read data |
| sint_clr | input | 1 | Soft-interrupt clear strobe |
| sint_clr_mask | input | 17 | Bits to clear when the strobe is high |
| softint | output | 17 | Sticky soft-interrupt vector |
| timer_irq | output | 1 | One-clock timer interrupt request |

## Verification
The bench targets the counter wrap at the 63-bit maximum, where a counter that carried into bit 63 would read back a huge value instead of a small one. It also writes counters with bit 63 set, which a wrong design would keep. It fires each channel against its compare value. A mis-routed match would set the wrong soft-interrupt bit, or, on the hypervisor channel, set one at all. A compare with the disable bit set must stay silent. A clear that collides with a new match must leave the bit set, and a clear-priority design would drop that interrupt. Interrupt pulses are checked to last exactly one clock, which a level-compare design would stretch.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned N_TMR    = 3;
  localparam int unsigned TMR_PROC = 0;
  localparam int unsigned TMR_SYS  = 1;
  localparam int unsigned TMR_HYP  = 2;

  typedef enum logic {
    FLD_COUNT = 1'b0,
    FLD_LIMIT = 1'b1
  } tick_field_e;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick_en
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_en = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else if (pre_q == PW'(DIV - 1)) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
      assign tick_en = (pre_q == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/tick_channel.sv
module tick_channel #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_we,
  input  logic             lim_we,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W:0]   lim_q,
  output logic             hit
);
  logic eq, eq_q;

  assign eq  = (cnt_q == lim_q[CNT_W-1:0]);
  assign hit = eq && !eq_q && !lim_q[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= {1'b1, {CNT_W{1'b0}}};
      eq_q  <= 1'b0;
    end else begin
      if (cnt_we)       cnt_q <= wr_data[CNT_W-1:0];
      else if (tick_en) cnt_q <= cnt_q + 1'b1;
      if (lim_we)       lim_q <= wr_data;
      eq_q <= eq;
    end
  end
endmodule

// File: rtl/tick_softint.sv
module tick_softint #(
  parameter int unsigned SOFT_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SOFT_W-1:0] set_vec,
  input  logic              any_hit,
  input  logic              clr,
  input  logic [SOFT_W-1:0] clr_mask,
  output logic [SOFT_W-1:0] softint,
  output logic              irq
);
  logic [SOFT_W-1:0] kill;

  assign kill = clr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      softint <= '0;
      irq     <= 1'b0;
    end else begin
      softint <= (softint & ~kill) | set_vec;
      irq     <= any_hit;
    end
  end
endmodule

// File: rtl/tick_cmp_bank.sv
module tick_cmp_bank #(
  parameter int unsigned CNT_W     = 63,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TICK_DIV  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_tmr,
  input  logic              wr_field,
  input  logic [CNT_W:0]    wr_data,
  input  logic [1:0]        rd_tmr,
  input  logic              rd_field,
  output logic [CNT_W:0]    rd_data,
  input  logic              sint_clr,
  input  logic [SOFT_W-1:0] sint_clr_mask,
  output logic [SOFT_W-1:0] softint,
  output logic              timer_irq
);
  import tick_pkg::*;

  localparam int unsigned SEL_W = 2;

  logic                 tick_en;
  logic [CNT_W-1:0]     cnt_q [N_TMR];
  logic [CNT_W:0]       lim_q [N_TMR];
  logic [N_TMR-1:0]     hit;
  logic [SOFT_W-1:0]    set_vec;

  tick_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en)
  );

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
      logic sel;
      assign sel = wr_en && (wr_tmr == SEL_W'(i));
      tick_channel #(.CNT_W(CNT_W)) u_ch (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .cnt_we (sel && (wr_field == FLD_COUNT)),
        .lim_we (sel && (wr_field == FLD_LIMIT)),
        .wr_data(wr_data),
        .cnt_q  (cnt_q[i]),
        .lim_q  (lim_q[i]),
        .hit    (hit[i])
      );
    end
  endgenerate

  always_comb begin
    set_vec            = '0;
    set_vec[TICK_BIT]  = hit[TMR_PROC];
    set_vec[STICK_BIT] = set_vec[STICK_BIT] | hit[TMR_SYS];
  end

  tick_softint #(.SOFT_W(SOFT_W)) u_sint (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .any_hit (|hit),
    .clr     (sint_clr),
    .clr_mask(sint_clr_mask),
    .softint (softint),
    .irq     (timer_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int i = 0; i < N_TMR; i++) begin
        if (rd_tmr == SEL_W'(i)) begin
          if (rd_field == FLD_LIMIT) rd_data <= lim_q[i];
          else                       rd_data <= {1'b0, cnt_q[i]};
        end
      end
    end
  end
endmodule

// File: rtl/tick_cmp_bank_chk.sv
module tick_cmp_bank_chk #(
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sint_clr,
  input logic [SOFT_W-1:0] sint_clr_mask,
  input logic [SOFT_W-1:0] softint,
  input logic              timer_irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!timer_irq && softint == '0)); // R1

  AST_TICK_SET_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(softint[TICK_BIT]) |-> timer_irq); // R6

  AST_STICK_SET_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(softint[STICK_BIT]) |-> timer_irq); // R7

  AST_TICK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (softint[TICK_BIT] && !(sint_clr && sint_clr_mask[TICK_BIT])) |=> softint[TICK_BIT]); // R10

  AST_STICK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (softint[STICK_BIT] && !(sint_clr && sint_clr_mask[STICK_BIT])) |=> softint[STICK_BIT]); // R10

  AST_CLR_OR_SET: assert property (@(posedge clk) disable iff (rst)
    (sint_clr && sint_clr_mask[TICK_BIT]) |=> (!softint[TICK_BIT] || timer_irq)); // R11
endmodule

bind tick_cmp_bank tick_cmp_bank_chk #(
  .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT), .STICK_BIT(STICK_BIT)
) u_chk (
  .clk(clk), .rst(rst), .sint_clr(sint_clr), .sint_clr_mask(sint_clr_mask),
  .softint(softint), .timer_irq(timer_irq)
);

// File: tb/test_tick_cmp_bank.sv
module test_tick_cmp_bank;
  localparam logic [63:0] MAXC = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] DIS  = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic [1:0]  tmr;
    logic [63:0] val;
    logic [7:0]  wait_n;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 64'h0000_0000_0000_0100, 8'd1,  64'h0000_0000_0000_0100},
    '{2'd1, 64'h0000_0000_0000_2000, 8'd5,  64'h0000_0000_0000_2004},
    '{2'd2, 64'h7FFF_FFFF_FFFF_FFFE, 8'd4,  64'h0000_0000_0000_0001},
    '{2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 8'd1,  64'h7FFF_FFFF_FFFF_FFFF},
    '{2'd1, 64'h0000_0000_0000_0000, 8'd10, 64'h0000_0000_0000_0009},
    '{2'd2, 64'h0123_4567_89AB_CDEF, 8'd2,  64'h0123_4567_89AB_CDF0},
    '{2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 8'd2,  64'h7FFF_FFFF_FFFF_FFF1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_tmr = '0;
  logic        wr_field = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_tmr = '0;
  logic        rd_field = 1'b0;
  logic [63:0] rd_data;
  logic        sint_clr = 1'b0;
  logic [16:0] sint_clr_mask = '0;
  logic [16:0] softint;
  logic        timer_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tick_cmp_bank i_tick_cmp_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tmr(wr_tmr), .wr_field(wr_field),
    .wr_data(wr_data), .rd_tmr(rd_tmr), .rd_field(rd_field), .rd_data(rd_data),
    .sint_clr(sint_clr), .sint_clr_mask(sint_clr_mask), .softint(softint),
    .timer_irq(timer_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] t, input logic f, input logic [63:0] d);
    wr_en = 1'b1; wr_tmr = t; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_clear(input logic [16:0] m);
    sint_clr = 1'b1; sint_clr_mask = m;
    @(negedge clk);
    sint_clr = 1'b0; sint_clr_mask = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    wait_n(4);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 softint", {47'd0, softint}, 64'd0);
    chk("R1 irq", {63'd0, timer_irq}, 64'd0);
    rd_field = 1'b1;
    for (int t = 0; t < 3; t++) begin
      rd_tmr = 2'(t);
      wait_n(1);
      chk("R1 compare reset", rd_data, DIS);
    end
    rd_field = 1'b0; rd_tmr = 2'd1;
    wait_n(1);
    a = rd_data;
    wait_n(3);
    chk("R1 counter runs", rd_data, a + 64'd3);

    // R2 R3 R4: write/readback vectors including wrap and bit 63 drop
    for (int v = 0; v < NV; v++) begin
      rd_tmr = VEC[v].tmr; rd_field = 1'b0;
      do_write(VEC[v].tmr, 1'b0, VEC[v].val);
      wait_n(int'(VEC[v].wait_n));
      chk("R3 readback", rd_data, VEC[v].exp);
    end

    // R4: compare readback
    rd_tmr = 2'd2; rd_field = 1'b1;
    do_write(2'd2, 1'b1, 64'h8000_0000_0000_1234);
    wait_n(1);
    chk("R4 compare read", rd_data, 64'h8000_0000_0000_1234);

    // R5: disabled compare stays silent
    do_write(2'd0, 1'b1, DIS | 64'h1005);
    do_write(2'd0, 1'b0, 64'h1000);
    wait_n(6);
    chk("R5 irq", {63'd0, timer_irq}, 64'd0);
    wait_n(1);
    chk("R5 softint", {47'd0, softint}, 64'd0);

    // R6 R9: processor channel match
    do_write(2'd0, 1'b1, 64'h1005);
    do_write(2'd0, 1'b0, 64'h1000);
    wait_n(5);
    chk("R6 irq early", {63'd0, timer_irq}, 64'd0);
    wait_n(1);
    chk("R6 irq", {63'd0, timer_irq}, 64'd1);
    chk("R6 softint", {47'd0, softint}, 64'h1);
    wait_n(1);
    chk("R9 single pulse", {63'd0, timer_irq}, 64'd0);

    // R7: system channel match
    do_write(2'd1, 1'b1, 64'h2003);
    do_write(2'd1, 1'b0, 64'h2000);
    wait_n(4);
    chk("R7 irq", {63'd0, timer_irq}, 64'd1);
    chk("R7 softint", {47'd0, softint}, 64'h10001);

    // R10: clear only masked bit
    do_clear(17'h10000);
    chk("R10 clear bit16", {47'd0, softint}, 64'h1);
    wait_n(3);
    chk("R10 sticky", {47'd0, softint}, 64'h1);

    // R8: hypervisor channel
    do_clear(17'h00001);
    chk("R10 clear bit0", {47'd0, softint}, 64'h0);
    do_write(2'd2, 1'b1, 64'h3003);
    do_write(2'd2, 1'b0, 64'h3000);
    wait_n(4);
    chk("R8 irq", {63'd0, timer_irq}, 64'd1);
    chk("R8 softint", {47'd0, softint}, 64'h0);

    // R11: clear collides with new match
    do_write(2'd0, 1'b1, 64'h4005);
    do_write(2'd0, 1'b0, 64'h3FFF);
    do_clear(17'h00001);
    do_write(2'd0, 1'b0, 64'h4000);
    wait_n(5);
    chk("R11 pre", {47'd0, softint}, 64'h0);
    sint_clr = 1'b1; sint_clr_mask = 17'h00001;
    @(negedge clk);
    sint_clr = 1'b0; sint_clr_mask = '0;
    chk("R11 set wins", {47'd0, softint}, 64'h1);
    chk("R11 irq", {63'd0, timer_irq}, 64'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule